// File: doc/BRIEF.md
# Keyboard Wake Interrupt Detector

This block watches eight port pins used as keypad or wake-up inputs. Software chooses which pins take part through a per-pin enable mask. Each enabled pin is brought into the bus clock domain by a two-stage synchronizer. The detector then compares its sample in one bus cycle with its sample in the next. A global polarity bit selects the active level. Active-low means a falling edge or low level counts. Active-high means a rising edge or high level counts.

A mode bit chooses between two detection modes. Edge-only mode sets the status flag on any qualifying transition. Edge-and-level mode sets it only when the enabled group leaves the all-idle state. In that mode the flag cannot be acknowledged away while any enabled pin is still active. The interrupt request is the flag gated by an enable bit. While the clock is stopped, a combinational wake output reports any enabled pin at its active level directly from the raw pins, with no synchronizer or clock in the path.

Software reaches two byte registers through a one-bit address.
- Address 0 is control/status.
- Address 1 is the pin enable mask.

Top module: `kbd_wake_detector`

## Requirements
- R1: The enable mask at address 1 resets to 0x00; bit n enables pin n. A pin whose mask bit is 0 never sets the flag and never drives the wake output.
- R2: The control register at address 0 resets to 0x00 and has these fields: bit 0 flag (read-only), bit 1 acknowledge (write 1, always reads 0), bit 2 interrupt enable, bit 3 level mode, bit 4 polarity (0 active-low, 1 active-high).
- R3: With polarity 0, an enabled pin sampled 1 and then 0 sets the flag. The flag is visible after the third rising clock edge that follows the pin change.
- R4: With polarity 1, an enabled pin sampled 0 and then 1 sets the flag. A 1-to-0 change does not set it.
- R5: A pin that is already active when it becomes enabled does not set the flag until it has first been seen inactive.
- R6: In edge mode (bit 3 = 0), an acknowledge clears the flag at the next clock edge whatever the pin levels are.
- R7: In level mode, the flag is set only when every enabled pin was inactive in the previous sample and at least one is active now. A pin becoming active while another enabled pin is already active does not set it.
- R8: In level mode, an acknowledge has no effect while any enabled pin is at its active level. It clears the flag once all enabled pins are inactive.
- R9: A change of the mask or of the polarity bit never produces a detection by itself.
- R10: When a detection and an acknowledge fall on the same clock edge, the flag ends up set.
- R11: The interrupt output equals the flag ANDed with the interrupt enable bit.
- R12: The wake output is 0 while the stop input is low. While it is high, the wake output follows the raw pins combinationally, asserting whenever any enabled pin is at its active level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | 8 | Raw keyboard pin levels |
| stop_i | input | 1 | High while the clock is stopped (low-power state) |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 control/status, 1 enable mask |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data, combinational on addr_i |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Asynchronous wake request |

## Verification
The acknowledge write and a new detection can land on the same clock edge. The bench provokes this by first setting the flag through one pin and returning that pin to idle. It then drives a fresh transition on a second pin and times the acknowledge write to the edge where the synchronized sample produces the detection. The flag must read back as set, and a later lone acknowledge must clear it. A second overlap is the acknowledge against a level that is still active in level mode: it is judged by reading the flag after acknowledges with one pin, then another, still held active.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
    localparam int DATA_W = 8;

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_MASK = 1'b1;

    localparam int BIT_FLAG = 0;
    localparam int BIT_ACK  = 1;
    localparam int BIT_IE   = 2;
    localparam int BIT_LVL  = 3;
    localparam int BIT_POL  = 4;

    typedef struct packed {
        logic pol;   // 1: active-high
        logic lvl;   // 1: edge-and-level mode
        logic ie;    // interrupt enable
    } kbd_cfg_t;

    function automatic logic [DATA_W-1:0] pack_ctrl(input kbd_cfg_t c, input logic flag);
        logic [DATA_W-1:0] v;
        v = '0;
        v[BIT_FLAG] = flag;
        v[BIT_IE]   = c.ie;
        v[BIT_LVL]  = c.lvl;
        v[BIT_POL]  = c.pol;
        return v;
    endfunction
endpackage

// File: rtl/kbd_sync.sv
module kbd_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg1;
    logic [W-1:0] stg2;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                stg1[i] <= 1'b0;
                stg2[i] <= 1'b0;
            end else begin
                stg1[i] <= d_i[i];
                stg2[i] <= stg1[i];
            end
        end
    end

    assign q_o = stg2;
endmodule

// File: rtl/kbd_edge_det.sv
module kbd_edge_det
    import kbd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] smp_i,
    input  logic [W-1:0] en_i,
    input  kbd_cfg_t     cfg_i,
    output logic         set_o,
    output logic         any_act_o
);
    logic [W-1:0] act_now;
    logic [W-1:0] act_prev;
    logic [W-1:0] en_d;
    logic         pol_d;
    logic         cfg_moved;
    logic         prev_any;
    logic         now_any;
    logic         edge_any;

    // map samples onto "active" sense for the selected polarity
    assign act_now = cfg_i.pol ? smp_i : ~smp_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_prev <= '0;
            en_d     <= '0;
            pol_d    <= 1'b0;
        end else begin
            act_prev <= act_now;   // reload every cycle, incl. after a config change
            en_d     <= en_i;
            pol_d    <= cfg_i.pol;
        end
    end

    assign cfg_moved = (en_i != en_d) || (cfg_i.pol != pol_d);
    assign prev_any  = |(act_prev & en_i);
    assign now_any   = |(act_now & en_i);
    assign edge_any  = |(act_now & ~act_prev & en_i);

    always_comb begin
        if (cfg_moved) begin
            set_o = 1'b0;
        end else if (cfg_i.lvl) begin
            set_o = !prev_any && now_any;
        end else begin
            set_o = edge_any;
        end
    end

    assign any_act_o = now_any;
endmodule

// File: rtl/kbd_regs.sv
module kbd_regs
    import kbd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic              addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              set_i,
    input  logic              any_act_i,
    output logic [W-1:0]      en_o,
    output kbd_cfg_t          cfg_o,
    output logic              flag_o,
    output logic [DATA_W-1:0] rdata_o
);
    logic ack;
    logic ack_ok;

    assign ack    = wr_en_i && (addr_i == ADDR_CTRL) && wdata_i[BIT_ACK];
    assign ack_ok = ack && !(cfg_o.lvl && any_act_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_o   <= '0;
            cfg_o  <= '0;
            flag_o <= 1'b0;
        end else begin
            if (wr_en_i && addr_i == ADDR_MASK) begin
                en_o <= wdata_i[W-1:0];
            end
            if (wr_en_i && addr_i == ADDR_CTRL) begin
                cfg_o.ie  <= wdata_i[BIT_IE];
                cfg_o.lvl <= wdata_i[BIT_LVL];
                cfg_o.pol <= wdata_i[BIT_POL];
            end
            if (set_i) begin
                flag_o <= 1'b1;
            end else if (ack_ok) begin
                flag_o <= 1'b0;
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_CTRL) begin
            rdata_o = pack_ctrl(cfg_o, flag_o);
        end else begin
            rdata_o[W-1:0] = en_o;
        end
    end
endmodule

// File: rtl/kbd_wake_detector.sv
module kbd_wake_detector
    import kbd_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NPINS-1:0]  pins_i,
    input  logic              stop_i,
    input  logic              wr_en_i,
    input  logic              addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o,
    output logic              wake_o
);
    logic [NPINS-1:0] pins_s;
    logic [NPINS-1:0] en_w;
    logic [NPINS-1:0] raw_act;
    kbd_cfg_t         cfg_w;
    logic             set_w;
    logic             any_act_w;
    logic             flag_w;

    kbd_sync #(.W(NPINS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (pins_i),
        .q_o (pins_s)
    );

    kbd_edge_det #(.W(NPINS)) u_det (
        .clk       (clk),
        .rst       (rst),
        .smp_i     (pins_s),
        .en_i      (en_w),
        .cfg_i     (cfg_w),
        .set_o     (set_w),
        .any_act_o (any_act_w)
    );

    kbd_regs #(.W(NPINS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .set_i     (set_w),
        .any_act_i (any_act_w),
        .en_o      (en_w),
        .cfg_o     (cfg_w),
        .flag_o    (flag_w),
        .rdata_o   (rdata_o)
    );

    assign irq_o = flag_w & cfg_w.ie;

    // clock-free path: raw pins, no synchronizer
    assign raw_act = cfg_w.pol ? pins_i : ~pins_i;
    assign wake_o  = stop_i & (|(raw_act & en_w));
endmodule

// File: rtl/kbd_wake_chk.sv
module kbd_wake_chk #(
    parameter int NPINS = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             stop_i,
    input logic             wake_o,
    input logic             irq_o,
    input logic             wr_en_i,
    input logic             addr_i,
    input logic [7:0]       wdata_i,
    input logic             flag,
    input logic             lvl,
    input logic             set_evt,
    input logic             any_act,
    input logic [NPINS-1:0] en
);
    // R1
    mask_off_chk: assert property (@(posedge clk) disable iff (rst)
        (en == '0) |-> !set_evt);

    // R6
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && !addr_i && wdata_i[1] && !lvl && !set_evt) |=> !flag);

    // R8
    level_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (flag && lvl && any_act) |=> flag);

    // R9
    cfg_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (en != $past(en)) |-> !set_evt);

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set_evt |=> flag);

    // R11
    irq_flag_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> flag);

    // R12
    wake_stop_chk: assert property (@(posedge clk) disable iff (rst)
        !stop_i |-> !wake_o);
endmodule

bind kbd_wake_detector kbd_wake_chk #(.NPINS(NPINS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .stop_i  (stop_i),
    .wake_o  (wake_o),
    .irq_o   (irq_o),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .flag    (flag_w),
    .lvl     (cfg_w.lvl),
    .set_evt (set_w),
    .any_act (any_act_w),
    .en      (en_w)
);

// File: tb/test_kbd_wake_detector.sv
module test_kbd_wake_detector;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] pins = 8'hFF;
    logic       stop = 1'b0;
    logic       wr_en = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq;
    logic       wake;

    int checks = 0;
    int fails  = 0;
    logic [7:0] ctrl_v = 8'h00;

    always #5 clk = ~clk;

    kbd_wake_detector i_kbd_wake_detector (
        .clk(clk), .rst(rst), .pins_i(pins), .stop_i(stop),
        .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .irq_o(irq), .wake_o(wake)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wdata = 8'h00;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic set_ctrl(input logic ie, input logic lvl, input logic pol);
        ctrl_v = {3'b000, pol, lvl, ie, 2'b00};
        wr(1'b0, ctrl_v);
    endtask

    task automatic ack();
        wr(1'b0, ctrl_v | 8'h02);
    endtask

    function automatic logic flag_of(input logic [7:0] c);
        return c[0];
    endfunction

    // fresh start: mask off, flag cleared, pins idle (active-low sense)
    task automatic clean(input logic [7:0] idle_pins);
        wr(1'b1, 8'h00);
        pins = idle_pins;
        set_ctrl(1'b0, 1'b0, 1'b0);
        idle(4);
        ack();
        idle(2);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(1'b0, v); check("R2 ctrl reset", v, 8'h00);
        rd(1'b1, v); check("R1 mask reset", v, 8'h00);
        check("R11 irq reset", {7'b0, irq}, 8'h00);
        check("R12 wake reset", {7'b0, wake}, 8'h00);
    endtask

    task automatic t_mask();
        logic [7:0] v;
        clean(8'hFF);
        wr(1'b1, 8'h01);
        set_ctrl(1'b1, 1'b0, 1'b0);
        rd(1'b0, v); check("R2 ctrl readback", v, 8'h04);
        idle(4);
        pins = 8'hF7;   // masked pin 3 falls
        idle(6);
        rd(1'b0, v); check("R1 masked pin ignored", {7'b0, flag_of(v)}, 8'h00);
        pins = 8'hFF;
        idle(4);
    endtask

    task automatic t_falling();
        logic [7:0] v;
        clean(8'hFF);
        wr(1'b1, 8'h01);
        set_ctrl(1'b1, 1'b0, 1'b0);
        idle(4);
        pins = 8'hFE;
        idle(2);
        rd(1'b0, v); check("R3 not yet set", {7'b0, flag_of(v)}, 8'h00);
        idle(1);
        rd(1'b0, v); check("R3 falling sets flag", {7'b0, flag_of(v)}, 8'h01);
        check("R11 irq with enable", {7'b0, irq}, 8'h01);
        wr(1'b0, ctrl_v & 8'hFB);
        check("R11 irq gated off", {7'b0, irq}, 8'h00);
        wr(1'b0, ctrl_v);
        ack();
        rd(1'b0, v); check("R6 ack clears with pin low", {7'b0, flag_of(v)}, 8'h00);
        idle(4);
        rd(1'b0, v); check("R6 stays clear", {7'b0, flag_of(v)}, 8'h00);
        rd(1'b0, v); check("R2 ack bit reads zero", v & 8'h02, 8'h00);
    endtask

    task automatic t_rising();
        logic [7:0] v;
        clean(8'hFF);
        wr(1'b1, 8'h01);
        idle(4);
        set_ctrl(1'b0, 1'b0, 1'b1);   // pins high are now active
        idle(4);
        rd(1'b0, v); check("R9 polarity change no edge", {7'b0, flag_of(v)}, 8'h00);
        pins = 8'h00;
        idle(5);
        rd(1'b0, v); check("R4 falling ignored active-high", {7'b0, flag_of(v)}, 8'h00);
        pins = 8'h01;
        idle(3);
        rd(1'b0, v); check("R4 rising sets flag", {7'b0, flag_of(v)}, 8'h01);
        set_ctrl(1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_prior();
        logic [7:0] v;
        clean(8'hFE);               // pin0 already low
        set_ctrl(1'b0, 1'b0, 1'b0);
        wr(1'b1, 8'h01);
        idle(5);
        rd(1'b0, v); check("R5 active at enable no flag", {7'b0, flag_of(v)}, 8'h00);
        check("R9 mask change no edge", {7'b0, flag_of(v)}, 8'h00);
        pins = 8'hFF;
        idle(4);
        pins = 8'hFE;
        idle(3);
        rd(1'b0, v); check("R5 after idle seen flag sets", {7'b0, flag_of(v)}, 8'h01);
    endtask

    task automatic t_level();
        logic [7:0] v;
        clean(8'hFE);               // pin0 low before enabling
        set_ctrl(1'b0, 1'b1, 1'b0);
        wr(1'b1, 8'h03);
        idle(4);
        pins = 8'hFC;               // pin1 falls while pin0 active
        idle(5);
        rd(1'b0, v); check("R7 other pin active no set", {7'b0, flag_of(v)}, 8'h00);
        pins = 8'hFF;
        idle(5);
        pins = 8'hFE;
        idle(3);
        rd(1'b0, v); check("R7 from all idle sets", {7'b0, flag_of(v)}, 8'h01);
        ack();
        rd(1'b0, v); check("R8 ack ignored pin0 active", {7'b0, flag_of(v)}, 8'h01);
        pins = 8'hFC;
        idle(3);
        pins = 8'hFD;
        idle(3);
        ack();
        rd(1'b0, v); check("R8 ack ignored pin1 active", {7'b0, flag_of(v)}, 8'h01);
        pins = 8'hFF;
        idle(4);
        ack();
        rd(1'b0, v); check("R8 ack clears when idle", {7'b0, flag_of(v)}, 8'h00);
    endtask

    task automatic t_collide();
        logic [7:0] v;
        clean(8'hFF);
        wr(1'b1, 8'h03);
        set_ctrl(1'b1, 1'b0, 1'b0);
        idle(4);
        pins = 8'hFD;
        idle(3);
        rd(1'b0, v); check("R3 pin1 sets flag", {7'b0, flag_of(v)}, 8'h01);
        pins = 8'hFF;
        idle(4);
        pins = 8'hFE;               // detection lands on the 3rd edge
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        wr_en = 1'b1; addr = 1'b0; wdata = ctrl_v | 8'h02;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0; wdata = 8'h00;
        rd(1'b0, v); check("R10 set beats ack", {7'b0, flag_of(v)}, 8'h01);
        ack();
        rd(1'b0, v); check("R10 later ack clears", {7'b0, flag_of(v)}, 8'h00);
    endtask

    task automatic t_wake();
        clean(8'hFF);
        wr(1'b1, 8'h01);
        pins = 8'hFE;
        #1;
        check("R12 no wake without stop", {7'b0, wake}, 8'h00);
        stop = 1'b1;
        #1;
        check("R12 wake on active pin", {7'b0, wake}, 8'h01);
        pins = 8'hFB;               // only masked pin 2 active
        #1;
        check("R1 masked pin no wake", {7'b0, wake}, 8'h00);
        pins = 8'hFF;
        #1;
        check("R12 wake drops", {7'b0, wake}, 8'h00);
        stop = 1'b0;
        idle(2);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        t_reset();
        t_mask();
        t_falling();
        t_rising();
        t_prior();
        t_level();
        t_collide();
        t_wake();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule